// File: doc/BRIEF.md
# Deep Sleep Power-Mode Controller

This block decides when a device may drop into its lowest-power state and keeps the device's pins safe while it is there. It watches a sleep request pin and two wake-feature enable bits. When sleep is requested and neither wake feature is enabled, it runs a short, fixed entry sequence and then holds the device in deep sleep. The sequence finishes while the system clock is still guaranteed to run, so the clock may stop afterwards. If either wake feature is enabled, the block goes to a lighter sleep state instead. In that state the wake-event inputs stay open and the interrupt path stays usable.

The block sits between the device core and its pads. On the output side it forces every functional pad to a parameterised idle level and turns off its output enable. On the input side it replaces ignored pad inputs with zero before they reach the core. It also holds the interrupt output low for a few cycles after any reset. Only a hardware reset brings the block out of deep sleep. Lowering the sleep pin, changing the wake bits and pulsing the soft reset all leave it in deep sleep.

Top module: `deep_sleep_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pm_state` reads 2'b00 (active). In that state every pad input, pad output, output enable and wake input passes through unchanged.
- R2: In active state, a clock edge that samples `sleep_pin`=1 with `auto_wake_en`=0 and `remote_wake_en`=0 moves `pm_state` to 2'b01 (entering). Counting that edge as the first, `pm_state` becomes 2'b11 (deep) after exactly ENTRY_LEN edges. ENTRY_LEN is between 2 and 5.
- R3: While entering, changes on `sleep_pin`, the wake enable bits and `soft_rst` do not alter the sequence or its length.
- R4: In active state, a clock edge that samples `sleep_pin`=1 with either wake enable bit set moves `pm_state` to 2'b10 (light).
- R5: In light state, an edge with `sleep_pin`=0 returns to 2'b00. An edge with `sleep_pin`=1 and both wake bits clear starts the entry sequence (2'b01) with the same length as in R2.
- R6: In the light, entering and deep states, `pad_oe` is all zero, `pad_out` equals the IDLE_LEVEL parameter and `core_in` is all zero.
- R7: In the entering and deep states, `wake_out` is all zero and `irq_out` is 0. In light state, `wake_out` follows `wake_in` and `irq_out` may follow `core_irq`.
- R8: Once in deep state, only `rst` leaves it. Any pattern on `sleep_pin`, the wake bits and `soft_rst` keeps `pm_state` at 2'b11.
- R9: After an edge that samples `rst`=1, `irq_out` stays 0 for the next IRQ_HOLDOFF edges. It follows `core_irq` from the IRQ_HOLDOFF-th edge with `rst`=0 onward. A `soft_rst` sampled in the active or light state restarts the same hold-off.
- R10: In active state, `irq_out` equals `core_irq` once the hold-off has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sleep_pin | input | 1 | Sleep request |
| auto_wake_en | input | 1 | Automatic wake feature enabled |
| remote_wake_en | input | 1 | Remote wake feature enabled |
| soft_rst | input | 1 | Software reset pulse from the core |
| pad_in | input | N_IN | Functional pad inputs |
| wake_in | input | N_WAKE | Wake-event inputs from the pads |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OUT | Output enables from the core |
| core_irq | input | 1 | Interrupt request from the core |
| core_in | output | N_IN | Gated pad inputs towards the core |
| wake_out | output | N_WAKE | Gated wake inputs towards the wake logic |
| pad_out | output | N_OUT | Output values towards the pads |
| pad_oe | output | N_OUT | Output enables towards the pads |
| irq_out | output | 1 | Interrupt towards the pad |
| pm_state | output | 2 | 00 active, 01 entering, 10 light, 11 deep |

## Verification
The bench builds the block with four pad inputs, four pad outputs, two wake inputs, an idle level of 4'b1010, ENTRY_LEN of 4 and IRQ_HOLDOFF of 3. With these widths the bench can sweep every value of the pad inputs and every core output and enable pattern in active state. It can also sweep all eight combinations of sleep pin and wake bits from active state, and all sixteen combinations of sleep, wake bits and soft reset while in deep state. The short entry and hold-off lengths let the bench check each one edge by edge.

// File: rtl/deep_sleep_pkg.sv
package deep_sleep_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'b00,
        PM_ENTERING = 2'b01,
        PM_LIGHT    = 2'b10,
        PM_DEEP     = 2'b11
    } pm_state_e;

    typedef struct packed {
        logic force_out_idle;
        logic block_func_in;
        logic block_wake_in;
        logic block_irq;
        logic accept_soft_rst;
    } gate_ctl_t;

    function automatic gate_ctl_t ctl_for_state(pm_state_e st);
        gate_ctl_t c;
        c.force_out_idle  = (st != PM_ACTIVE);
        c.block_func_in   = (st != PM_ACTIVE);
        c.block_wake_in   = (st == PM_ENTERING) || (st == PM_DEEP);
        c.block_irq       = (st == PM_ENTERING) || (st == PM_DEEP);
        c.accept_soft_rst = (st == PM_ACTIVE) || (st == PM_LIGHT);
        return c;
    endfunction

    function automatic logic wake_features_off(logic auto_en, logic remote_en);
        return !auto_en && !remote_en;
    endfunction

endpackage

// File: rtl/deep_sleep_fsm.sv
module deep_sleep_fsm
    import deep_sleep_pkg::*;
#(
    parameter int ENTRY_LEN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_pin,
    input  logic      auto_wake_en,
    input  logic      remote_wake_en,
    output pm_state_e state
);
    localparam int CW = $clog2(ENTRY_LEN + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(ENTRY_LEN - 1);

    pm_state_e      state_q, state_d;
    logic [CW-1:0]  step_q, step_d;
    logic           deep_ok;

    assign deep_ok = sleep_pin && wake_features_off(auto_wake_en, remote_wake_en);

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            PM_ACTIVE: begin
                if (deep_ok) begin
                    state_d = PM_ENTERING;
                    step_d  = CW'(1);
                end else if (sleep_pin) begin
                    state_d = PM_LIGHT;
                end
            end
            PM_LIGHT: begin
                if (!sleep_pin) begin
                    state_d = PM_ACTIVE;
                end else if (deep_ok) begin
                    state_d = PM_ENTERING;
                    step_d  = CW'(1);
                end
            end
            PM_ENTERING: begin
                if (step_q == LAST_STEP) begin
                    state_d = PM_DEEP;
                    step_d  = '0;
                end else begin
                    step_d = step_q + CW'(1);
                end
            end
            PM_DEEP: begin
                state_d = PM_DEEP;
            end
            default: begin
                state_d = PM_ACTIVE;
                step_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_ACTIVE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/deep_sleep_out_stage.sv
module deep_sleep_out_stage #(
    parameter int               N_OUT      = 4,
    parameter logic [N_OUT-1:0] IDLE_LEVEL = '0
) (
    input  logic             force_idle,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_pin
        always_comb begin
            if (force_idle) begin
                pad_out[i] = IDLE_LEVEL[i];
                pad_oe[i]  = 1'b0;
            end else begin
                pad_out[i] = core_out[i];
                pad_oe[i]  = core_oe[i];
            end
        end
    end

endmodule

// File: rtl/deep_sleep_in_stage.sv
module deep_sleep_in_stage #(
    parameter int N_IN   = 4,
    parameter int N_WAKE = 2
) (
    input  logic              block_func,
    input  logic              block_wake,
    input  logic [N_IN-1:0]   pad_in,
    input  logic [N_WAKE-1:0] wake_in,
    output logic [N_IN-1:0]   core_in,
    output logic [N_WAKE-1:0] wake_out
);
    for (genvar i = 0; i < N_IN; i++) begin : g_func
        assign core_in[i] = pad_in[i] & ~block_func;
    end

    for (genvar j = 0; j < N_WAKE; j++) begin : g_wake
        assign wake_out[j] = wake_in[j] & ~block_wake;
    end

endmodule

// File: rtl/deep_sleep_irq_guard.sv
module deep_sleep_irq_guard #(
    parameter int IRQ_HOLDOFF = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic accept_soft,
    input  logic block_irq,
    input  logic core_irq,
    output logic irq_out
);
    localparam int HW = $clog2(IRQ_HOLDOFF + 1);
    localparam logic [HW-1:0] HOLD_INIT = HW'(IRQ_HOLDOFF);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= HOLD_INIT;
        end else if (soft_rst && accept_soft) begin
            hold_q <= HOLD_INIT;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
        end
    end

    assign irq_out = core_irq && !block_irq && (hold_q == '0);

endmodule

// File: rtl/deep_sleep_ctrl.sv
module deep_sleep_ctrl
    import deep_sleep_pkg::*;
#(
    parameter int               N_IN        = 4,
    parameter int               N_OUT       = 4,
    parameter int               N_WAKE      = 2,
    parameter logic [N_OUT-1:0] IDLE_LEVEL  = 4'b1010,
    parameter int               ENTRY_LEN   = 4,
    parameter int               IRQ_HOLDOFF = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_pin,
    input  logic              auto_wake_en,
    input  logic              remote_wake_en,
    input  logic              soft_rst,
    input  logic [N_IN-1:0]   pad_in,
    input  logic [N_WAKE-1:0] wake_in,
    input  logic [N_OUT-1:0]  core_out,
    input  logic [N_OUT-1:0]  core_oe,
    input  logic              core_irq,
    output logic [N_IN-1:0]   core_in,
    output logic [N_WAKE-1:0] wake_out,
    output logic [N_OUT-1:0]  pad_out,
    output logic [N_OUT-1:0]  pad_oe,
    output logic              irq_out,
    output logic [1:0]        pm_state
);
    pm_state_e state;
    gate_ctl_t ctl;

    deep_sleep_fsm #(.ENTRY_LEN(ENTRY_LEN)) fsm_i (
        .clk            (clk),
        .rst            (rst),
        .sleep_pin      (sleep_pin),
        .auto_wake_en   (auto_wake_en),
        .remote_wake_en (remote_wake_en),
        .state          (state)
    );

    assign ctl      = ctl_for_state(state);
    assign pm_state = state;

    deep_sleep_out_stage #(.N_OUT(N_OUT), .IDLE_LEVEL(IDLE_LEVEL)) out_i (
        .force_idle (ctl.force_out_idle),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    deep_sleep_in_stage #(.N_IN(N_IN), .N_WAKE(N_WAKE)) in_i (
        .block_func (ctl.block_func_in),
        .block_wake (ctl.block_wake_in),
        .pad_in     (pad_in),
        .wake_in    (wake_in),
        .core_in    (core_in),
        .wake_out   (wake_out)
    );

    deep_sleep_irq_guard #(.IRQ_HOLDOFF(IRQ_HOLDOFF)) irq_i (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst),
        .accept_soft (ctl.accept_soft_rst),
        .block_irq   (ctl.block_irq),
        .core_irq    (core_irq),
        .irq_out     (irq_out)
    );

endmodule

// File: rtl/deep_sleep_ctrl_chk.sv
module deep_sleep_ctrl_chk #(
    parameter int               N_IN        = 4,
    parameter int               N_OUT       = 4,
    parameter int               N_WAKE      = 2,
    parameter logic [N_OUT-1:0] IDLE_LEVEL  = 4'b1010,
    parameter int               ENTRY_LEN   = 4,
    parameter int               IRQ_HOLDOFF = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_pin,
    input logic              auto_wake_en,
    input logic              remote_wake_en,
    input logic              soft_rst,
    input logic [N_WAKE-1:0] wake_in,
    input logic [N_IN-1:0]   core_in,
    input logic [N_WAKE-1:0] wake_out,
    input logic [N_OUT-1:0]  pad_out,
    input logic [N_OUT-1:0]  pad_oe,
    input logic              irq_out,
    input logic [1:0]        pm_state
);
    logic [7:0] ent_cycles;

    always_ff @(posedge clk) begin
        if (rst || pm_state != 2'b01) ent_cycles <= '0;
        else                          ent_cycles <= ent_cycles + 8'd1;
    end

    initial begin
        a_r2_entry_len_range: assert (ENTRY_LEN >= 2 && ENTRY_LEN <= 5);
    end

    a_r2_enter_on_request: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'b00 && sleep_pin && !auto_wake_en && !remote_wake_en)
        |=> (pm_state == 2'b01));

    a_r2_entry_bounded: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'b01) |-> (ent_cycles < 8'(ENTRY_LEN - 1)));

    a_r4_light_on_wake: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'b00 && sleep_pin && (auto_wake_en || remote_wake_en))
        |=> (pm_state == 2'b10));

    a_r5_light_exit: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'b10 && !sleep_pin) |=> (pm_state == 2'b00));

    a_r6_pads_idle: assert property (@(posedge clk) disable iff (rst)
        (pm_state != 2'b00) |-> (pad_oe == '0 && pad_out == IDLE_LEVEL && core_in == '0));

    a_r7_deep_quiet: assert property (@(posedge clk) disable iff (rst)
        (pm_state[0]) |-> (wake_out == '0 && !irq_out));

    a_r7_light_wake_open: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'b10) |-> (wake_out == wake_in));

    a_r8_deep_sticky: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'b11) |=> (pm_state == 2'b11));

    a_r9_no_irq_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_out);

    a_r9_no_irq_after_soft: assert property (@(posedge clk) disable iff (rst)
        ($past(soft_rst) && !$past(pm_state[0])) |-> !irq_out);

endmodule

bind deep_sleep_ctrl deep_sleep_ctrl_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_WAKE(N_WAKE), .IDLE_LEVEL(IDLE_LEVEL),
    .ENTRY_LEN(ENTRY_LEN), .IRQ_HOLDOFF(IRQ_HOLDOFF)
) chk_i (
    .clk(clk), .rst(rst), .sleep_pin(sleep_pin), .auto_wake_en(auto_wake_en),
    .remote_wake_en(remote_wake_en), .soft_rst(soft_rst), .wake_in(wake_in),
    .core_in(core_in), .wake_out(wake_out), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_out(irq_out), .pm_state(pm_state)
);

// File: tb/deep_sleep_ctrl_tb_top.sv
module deep_sleep_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int NW = 2;
    localparam logic [NO-1:0] IDLE = 4'b1010;
    localparam int ELEN = 4;
    localparam int HOLD = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_pin = 1'b0;
    logic          auto_wake_en = 1'b0;
    logic          remote_wake_en = 1'b0;
    logic          soft_rst = 1'b0;
    logic [NI-1:0] pad_in = '0;
    logic [NW-1:0] wake_in = '0;
    logic [NO-1:0] core_out = '0;
    logic [NO-1:0] core_oe = '0;
    logic          core_irq = 1'b0;
    logic [NI-1:0] core_in;
    logic [NW-1:0] wake_out;
    logic [NO-1:0] pad_out;
    logic [NO-1:0] pad_oe;
    logic          irq_out;
    logic [1:0]    pm_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deep_sleep_ctrl #(
        .N_IN(NI), .N_OUT(NO), .N_WAKE(NW), .IDLE_LEVEL(IDLE),
        .ENTRY_LEN(ELEN), .IRQ_HOLDOFF(HOLD)
    ) dut_i (
        .clk(clk), .rst(rst), .sleep_pin(sleep_pin), .auto_wake_en(auto_wake_en),
        .remote_wake_en(remote_wake_en), .soft_rst(soft_rst), .pad_in(pad_in),
        .wake_in(wake_in), .core_out(core_out), .core_oe(core_oe), .core_irq(core_irq),
        .core_in(core_in), .wake_out(wake_out), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_out(irq_out), .pm_state(pm_state)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic hw_reset();
        rst = 1'b1;
        sleep_pin = 1'b0; auto_wake_en = 1'b0; remote_wake_en = 1'b0; soft_rst = 1'b0;
        tick(); tick();
        rst = 1'b0;
        #1;
    endtask

    task automatic chk_state(input string req, input logic [1:0] exp);
        chk(pm_state == exp, req, "pm_state", int'(pm_state), int'(exp));
    endtask

    // idle pads and gated inputs for any non-active state (R6)
    task automatic chk_idle(input string req);
        pad_in = 4'hF; core_out = 4'h5; core_oe = 4'hF;
        #1;
        chk(pad_oe == '0, req, "pad_oe", int'(pad_oe), 0);
        chk(pad_out == IDLE, req, "pad_out", int'(pad_out), int'(IDLE));
        chk(core_in == '0, req, "core_in", int'(core_in), 0);
    endtask

    task automatic expire_hold();
        for (int k = 0; k < HOLD; k++) tick();
    endtask

    initial begin
        // R1: reset state
        hw_reset();
        chk_state("R1", 2'b00);
        pad_in = 4'h9; core_out = 4'h6; core_oe = 4'h3; wake_in = 2'b10;
        #1;
        chk(core_in == 4'h9 && pad_out == 4'h6 && pad_oe == 4'h3 && wake_out == 2'b10,
            "R1", "passthrough after reset",
            int'({core_in, pad_out, pad_oe}), int'({4'h9, 4'h6, 4'h3}));

        // R9: hold-off after hardware reset
        core_irq = 1'b1;
        hw_reset();
        core_irq = 1'b1;
        #1;
        chk(irq_out == 1'b0, "R9", "irq right after reset", int'(irq_out), 0);
        for (int k = 1; k <= HOLD + 2; k++) begin
            tick();
            chk(irq_out == (k >= HOLD), "R9", "irq after hw reset",
                int'(irq_out), int'(k >= HOLD));
        end
        // R9: hold-off after soft reset in active
        soft_rst = 1'b1; tick(); soft_rst = 1'b0; #1;
        chk(irq_out == 1'b0, "R9", "irq after soft reset edge", int'(irq_out), 0);
        for (int k = 1; k <= HOLD + 1; k++) begin
            tick();
            chk(irq_out == (k >= HOLD), "R9", "irq after soft reset",
                int'(irq_out), int'(k >= HOLD));
        end
        // R10: irq follows core_irq in active
        for (int v = 0; v < 2; v++) begin
            core_irq = v[0]; #1;
            chk(irq_out == v[0], "R10", "irq passthrough", int'(irq_out), v);
        end

        // R1: full passthrough sweep in active state
        for (int v = 0; v < 16; v++) begin
            pad_in = v[3:0]; core_out = ~v[3:0]; core_oe = v[3:0] ^ 4'h6; wake_in = v[1:0];
            #1;
            chk(core_in == v[3:0] && pad_out == ~v[3:0] && pad_oe == (v[3:0] ^ 4'h6)
                && wake_out == v[1:0], "R1", "active sweep", int'(core_in), v);
        end

        // R2/R4: every sleep/wake combination from active
        for (int c = 0; c < 8; c++) begin
            logic [1:0] exp_st;
            hw_reset();
            sleep_pin = c[2]; auto_wake_en = c[1]; remote_wake_en = c[0];
            tick();
            exp_st = !c[2] ? 2'b00 : (c[1:0] == 2'b00 ? 2'b01 : 2'b10);
            chk_state(exp_st == 2'b01 ? "R2" : "R4", exp_st);
        end

        // R2/R3: entry sequence length with disturbed inputs, then deep state
        hw_reset();
        expire_hold();
        core_irq = 1'b1;
        sleep_pin = 1'b1;
        tick();
        chk_state("R2", 2'b01);
        chk_idle("R6");
        wake_in = 2'b11; #1;
        chk(wake_out == 2'b00 && irq_out == 1'b0, "R7", "entering quiet",
            int'({wake_out, irq_out}), 0);
        for (int e = 2; e <= ELEN; e++) begin
            sleep_pin = e[0]; auto_wake_en = e[1]; remote_wake_en = ~e[0]; soft_rst = e[0];
            tick();
            chk_state("R3", e == ELEN ? 2'b11 : 2'b01);
        end
        soft_rst = 1'b0;
        chk_idle("R6");
        wake_in = 2'b01; #1;
        chk(wake_out == 2'b00 && irq_out == 1'b0, "R7", "deep quiet",
            int'({wake_out, irq_out}), 0);

        // R8: deep is sticky against every input pattern
        for (int c = 0; c < 16; c++) begin
            sleep_pin = c[3]; auto_wake_en = c[2]; remote_wake_en = c[1]; soft_rst = c[0];
            tick();
            chk_state("R8", 2'b11);
            chk(pad_oe == '0 && irq_out == 1'b0, "R8", "deep outputs",
                int'({pad_oe, irq_out}), 0);
        end
        // R8: only hardware reset leaves deep
        hw_reset();
        chk_state("R8", 2'b00);

        // R5/R6/R7: light state behaviour and exits
        for (int w = 1; w < 4; w++) begin
            hw_reset();
            expire_hold();
            sleep_pin = 1'b1; auto_wake_en = w[1]; remote_wake_en = w[0];
            tick();
            chk_state("R4", 2'b10);
            chk_idle("R6");
            wake_in = w[1:0]; core_irq = 1'b1; #1;
            chk(wake_out == w[1:0], "R7", "light wake open", int'(wake_out), w);
            chk(irq_out == 1'b1, "R7", "light irq", int'(irq_out), 1);
            if (w == 3) begin
                // R5: clearing wake bits in light starts entry
                auto_wake_en = 1'b0; remote_wake_en = 1'b0;
                for (int e = 1; e <= ELEN; e++) begin
                    tick();
                    chk_state("R5", e == ELEN ? 2'b11 : 2'b01);
                end
            end else begin
                sleep_pin = 1'b0;
                tick();
                chk_state("R5", 2'b00);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule